// File: doc/BRIEF.md
# Flash Status Polling Match Engine

This block repeatedly reads a status value back from an external flash device and checks it against a programmed reference value under a bit mask. It raises a sticky match flag when a read satisfies the selected rule. There are two combining rules. In all-bits mode, every enabled bit must agree with the reference. In any-bit mode, a single agreeing enabled bit is enough. The engine either finishes at the first hit or keeps polling until software aborts it or takes away the enable.

The bus transaction behind each read is outside this block. The engine raises `poll_req` and holds it until the response arrives as `rsp_valid` together with `rsp_data`. When the engine keeps polling after a response, it waits a programmable number of cycles before it raises the next request. The status value can be 1 to 4 bytes wide, as selected by `cfg_size`.

Top module: `status_poll_engine`

## Requirements
- R1: With `cfg_or_mode`=0 (all-bits mode), a response hits only when every enabled bit of `rsp_data` equals the same bit of `cfg_match`. When at least one enabled bit differs, the response is a miss.
- R2: With `cfg_or_mode`=1 (any-bit mode), a response hits when at least one enabled bit of `rsp_data` equals the same bit of `cfg_match`.
- R3: A bit is enabled only where `cfg_mask` holds 1. Bits where the mask is 0 never affect the result. An all-zero mask never hits in any-bit mode and always hits in all-bits mode.
- R4: `cfg_size` value n selects n+1 bytes, counted from bits 7:0 upward. Bits above the selected bytes are treated as masked.
- R5: With `cfg_stop_on_match`=1, a hitting response returns the engine to idle on the next cycle, with `busy`=0 and `poll_req`=0.
- R6: With `cfg_stop_on_match`=0, the engine stays busy after every response, and each hitting response sets `match_flag`.
- R7: After a response that does not stop the engine, `poll_req` stays low for exactly `cfg_interval` cycles and then rises. With `cfg_interval`=0, `poll_req` stays high into the next poll.
- R8: `match_flag` is sticky and is cleared only by `clr_match`, one cycle after the clear. When a hit and a clear arrive in the same cycle, the hit wins.
- R9: `abort`=1 or `enable`=0 puts the engine in idle on the next cycle and drops `poll_req`. A response that arrives in that same cycle is discarded and does not set `match_flag`.
- R10: The mode and stop settings are captured at start. Changes to them while `busy`=1 have no effect on the running poll.
- R11: Reset sets `busy`, `poll_req` and `match_flag` to 0.
- R12: A `start` pulse begins polling only when `enable`=1 and the engine is idle. `poll_req` is high on the cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Engine enable; low forces idle |
| start | input | 1 | Pulse that begins polling |
| abort | input | 1 | Pulse that stops polling at once |
| clr_match | input | 1 | Clears the sticky match flag |
| cfg_or_mode | input | 1 | 0 = all-bits mode, 1 = any-bit mode |
| cfg_stop_on_match | input | 1 | 1 = finish at the first hit |
| cfg_size | input | 2 | Status width in bytes, minus one |
| cfg_mask | input | 32 | Per-bit compare enable |
| cfg_match | input | 32 | Reference value |
| cfg_interval | input | 16 | Cycles between a response and the next request |
| poll_req | output | 1 | Request for the next status read |
| rsp_valid | input | 1 | Status read data is valid |
| rsp_data | input | 32 | Status read data |
| busy | output | 1 | Engine is polling |
| match_flag | output | 1 | Sticky status-match flag |

## Verification
The hardest case to reach is a response that arrives in the same cycle as an abort. A bench that simply waits for the response never produces it. The stimulus holds the engine in the request state, then drives `rsp_valid` with hitting data and `abort` high at the same negative edge, and checks that the flag stays clear. A similar deliberate overlap is used twice more. The first puts `clr_match` in the same cycle as a hitting response. The second changes the mode input mid-poll, using data that hits only under the new mode.

// File: rtl/sp_pkg.sv
// Package: shared types for the status polling match engine.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package sp_pkg;

    typedef enum logic [1:0] {
        SP_IDLE = 2'd0,
        SP_REQ  = 2'd1,
        SP_WAIT = 2'd2
    } sp_state_e;

endpackage

// File: rtl/sp_match_eval.sv
// Module: sp_match_eval
// Purely combinational. Decides whether one status value hits the reference
// under the mask, the byte-size limit and the combining rule.
// Assumes: byte 0 is bits 7:0, and size n enables bytes 0..n.
module sp_match_eval #(
    parameter int BYTES  = 4,
    parameter int SIZE_W = (BYTES > 1) ? $clog2(BYTES) : 1,
    parameter int DATA_W = 8 * BYTES
) (
    input  logic              or_mode,
    input  logic [SIZE_W-1:0] size,
    input  logic [DATA_W-1:0] mask,
    input  logic [DATA_W-1:0] ref_val,
    input  logic [DATA_W-1:0] data,
    output logic              hit
);

    logic [DATA_W-1:0] size_mask;
    logic [DATA_W-1:0] eff_mask;
    logic [DATA_W-1:0] agree;

    // One enable byte for each status byte, set when the byte lies within the selected size.
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        localparam int unsigned BI = b;
        localparam logic [SIZE_W:0] BIDX = (SIZE_W+1)'(BI);
        assign size_mask[b*8 +: 8] = ({1'b0, size} >= BIDX) ? 8'hFF : 8'h00;
    end

    // Combine the mask with the size limit and apply the selected combining rule.
    always_comb begin
        eff_mask = mask & size_mask;
        agree    = ~(data ^ ref_val);
        if (or_mode) begin
            hit = |(agree & eff_mask);
        end else begin
            hit = &(agree | ~eff_mask);
        end
    end

endmodule

// File: rtl/sp_gap_timer.sv
// Module: sp_gap_timer
// Counts down the interval between a response and the next poll request.
// Assumes: load and run are never high together; load_val > 0 whenever it is loaded.
module sp_gap_timer #(
    parameter int GAP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GAP_W-1:0] load_val,
    input  logic             run,
    output logic             done
);

    logic [GAP_W-1:0] cnt_q;

    // Load on request, otherwise count down while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = run && (cnt_q == GAP_W'(1));

endmodule

// File: rtl/sp_ctrl.sv
// Module: sp_ctrl
// Sequencer for polling: idle, request outstanding, and waiting out the interval.
// Assumes: hit is valid whenever rsp_valid is high, and stop_q is the captured stop setting.
module sp_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic start,
    input  logic abort,
    input  logic rsp_valid,
    input  logic hit,
    input  logic stop_q,
    input  logic interval_zero,
    input  logic gap_done,
    output logic poll_req,
    output logic busy,
    output logic gap_load,
    output logic gap_run,
    output logic cfg_capture,
    output logic hit_event
);
    import sp_pkg::*;

    sp_state_e state_q, state_d;

    // Next state. Abort or a dropped enable override everything else.
    always_comb begin
        state_d     = state_q;
        gap_load    = 1'b0;
        cfg_capture = 1'b0;
        if (!enable || abort) begin
            state_d = SP_IDLE;
        end else begin
            unique case (state_q)
                SP_IDLE: begin
                    if (start) begin
                        state_d     = SP_REQ;
                        cfg_capture = 1'b1;
                    end
                end
                SP_REQ: begin
                    if (rsp_valid) begin
                        if (hit && stop_q) begin
                            state_d = SP_IDLE;
                        end else if (interval_zero) begin
                            state_d = SP_REQ;
                        end else begin
                            state_d  = SP_WAIT;
                            gap_load = 1'b1;
                        end
                    end
                end
                SP_WAIT: begin
                    if (gap_done) begin
                        state_d = SP_REQ;
                    end
                end
                default: state_d = SP_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign poll_req  = (state_q == SP_REQ);
    assign busy      = (state_q != SP_IDLE);
    assign gap_run   = (state_q == SP_WAIT);
    assign hit_event = (state_q == SP_REQ) && rsp_valid && hit && enable && !abort;

endmodule

// File: rtl/status_poll_engine.sv
// Module: status_poll_engine (top)
// Polls a flash status value and flags a hit against a masked reference value.
// Assumes: the responder answers each poll_req with a one-cycle rsp_valid.
module status_poll_engine #(
    parameter int BYTES  = 4,
    parameter int GAP_W  = 16,
    parameter int SIZE_W = (BYTES > 1) ? $clog2(BYTES) : 1,
    parameter int DATA_W = 8 * BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              start,
    input  logic              abort,
    input  logic              clr_match,
    input  logic              cfg_or_mode,
    input  logic              cfg_stop_on_match,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic [DATA_W-1:0] cfg_mask,
    input  logic [DATA_W-1:0] cfg_match,
    input  logic [GAP_W-1:0]  cfg_interval,
    output logic              poll_req,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              busy,
    output logic              match_flag
);

    logic or_mode_q;
    logic stop_q;
    logic cmp_hit;
    logic gap_load;
    logic gap_run;
    logic gap_done;
    logic cfg_capture;
    logic hit_event;

    sp_match_eval #(.BYTES(BYTES), .SIZE_W(SIZE_W), .DATA_W(DATA_W)) u_eval (
        .or_mode (or_mode_q),
        .size    (cfg_size),
        .mask    (cfg_mask),
        .ref_val (cfg_match),
        .data    (rsp_data),
        .hit     (cmp_hit)
    );

    sp_gap_timer #(.GAP_W(GAP_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (cfg_interval),
        .run      (gap_run),
        .done     (gap_done)
    );

    sp_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .start         (start),
        .abort         (abort),
        .rsp_valid     (rsp_valid),
        .hit           (cmp_hit),
        .stop_q        (stop_q),
        .interval_zero (cfg_interval == '0),
        .gap_done      (gap_done),
        .poll_req      (poll_req),
        .busy          (busy),
        .gap_load      (gap_load),
        .gap_run       (gap_run),
        .cfg_capture   (cfg_capture),
        .hit_event     (hit_event)
    );

    // Capture the mode settings only when a poll starts from idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            or_mode_q <= 1'b0;
            stop_q    <= 1'b0;
        end else if (cfg_capture) begin
            or_mode_q <= cfg_or_mode;
            stop_q    <= cfg_stop_on_match;
        end
    end

    // Sticky match flag. A new hit takes priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_flag <= 1'b0;
        end else if (hit_event) begin
            match_flag <= 1'b1;
        end else if (clr_match) begin
            match_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/sp_poll_checker.sv
// Module: sp_poll_checker
// Temporal properties of the polling engine, bound into the top module.
// Assumes: it sees the top's ports and the compare result and captured settings.
module sp_poll_checker (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic abort,
    input logic clr_match,
    input logic rsp_valid,
    input logic poll_req,
    input logic busy,
    input logic match_flag,
    input logic hit,
    input logic or_q,
    input logic stop_q
);

    // R11: reset clears all outputs
    a_r11_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!busy && !poll_req && !match_flag));

    // R5: a hit in stop mode returns the engine to idle
    a_r5_stop_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_req && rsp_valid && hit && stop_q && enable && !abort) |=> !busy);

    // R6: every accepted hit sets the flag
    a_r6_hit_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_req && rsp_valid && hit && enable && !abort) |=> match_flag);

    // R8: the flag only falls after a clear
    a_r8_sticky_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (match_flag && !clr_match) |=> match_flag);

    // R9: abort or disable reaches idle in one cycle
    a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (abort || !enable) |=> (!busy && !poll_req));

    // R10: captured settings hold while busy
    a_r10_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(or_q) && $stable(stop_q)));

    // R7: a request is only made while busy
    a_r7_req_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        poll_req |-> busy);

endmodule

bind status_poll_engine sp_poll_checker u_sp_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .abort      (abort),
    .clr_match  (clr_match),
    .rsp_valid  (rsp_valid),
    .poll_req   (poll_req),
    .busy       (busy),
    .match_flag (match_flag),
    .hit        (cmp_hit),
    .or_q       (or_mode_q),
    .stop_q     (stop_q)
);

// File: tb/status_poll_engine_bench.sv
module status_poll_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        start = 1'b0;
    logic        abort = 1'b0;
    logic        clr_match = 1'b0;
    logic        cfg_or_mode = 1'b0;
    logic        cfg_stop_on_match = 1'b0;
    logic [1:0]  cfg_size = 2'd3;
    logic [31:0] cfg_mask = '0;
    logic [31:0] cfg_match = '0;
    logic [15:0] cfg_interval = '0;
    logic        poll_req;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_data = '0;
    logic        busy;
    logic        match_flag;

    int nchk  = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    status_poll_engine u_status_poll_engine (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start(start), .abort(abort),
        .clr_match(clr_match), .cfg_or_mode(cfg_or_mode),
        .cfg_stop_on_match(cfg_stop_on_match), .cfg_size(cfg_size),
        .cfg_mask(cfg_mask), .cfg_match(cfg_match), .cfg_interval(cfg_interval),
        .poll_req(poll_req), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .busy(busy), .match_flag(match_flag)
    );

    typedef struct packed {
        logic        orm;
        logic [1:0]  size;
        logic [31:0] mask;
        logic [31:0] ref_v;
        logic [31:0] data;
        logic        exp_hit;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd3, 32'hFFFF_FFFF, 32'h1234_5678, 32'h1234_5678, 1'b1}, // R1 all agree
        '{1'b0, 2'd3, 32'hFFFF_FFFF, 32'h1234_5678, 32'h1234_5679, 1'b0}, // R1 one differs
        '{1'b0, 2'd0, 32'hFFFF_FFFF, 32'h0000_00AA, 32'h5566_77AA, 1'b1}, // R4 upper bytes ignored
        '{1'b0, 2'd1, 32'h0000_FF00, 32'h0000_AB00, 32'h0000_AB11, 1'b1}, // R3 masked low byte
        '{1'b1, 2'd3, 32'h0000_00F0, 32'h0000_00F0, 32'h0000_0080, 1'b1}, // R2 one bit agrees
        '{1'b1, 2'd3, 32'h0000_00F0, 32'h0000_00F0, 32'h0000_000F, 1'b0}, // R2 none agrees
        '{1'b1, 2'd3, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1'b0}, // R3 zero mask any-bit
        '{1'b0, 2'd3, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1}, // R3 zero mask all-bits
        '{1'b1, 2'd0, 32'hFF00_0000, 32'hFF00_0000, 32'hFF00_0000, 1'b0}, // R4 byte above size
        '{1'b0, 2'd2, 32'hFFFF_FFFF, 32'h0012_3456, 32'hAA12_3456, 1'b1}  // R4 three bytes
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic start_poll(input logic orm, input logic stp, input logic [1:0] sz,
                              input logic [31:0] msk, input logic [31:0] rf,
                              input logic [15:0] gap);
        cfg_or_mode = orm; cfg_stop_on_match = stp; cfg_size = sz;
        cfg_mask = msk; cfg_match = rf; cfg_interval = gap;
        start = 1'b1;
        tick();
        start = 1'b0;
    endtask

    task automatic respond(input logic [31:0] d);
        rsp_valid = 1'b1; rsp_data = d;
        tick();
        rsp_valid = 1'b0;
    endtask

    task automatic pulse_clear();
        clr_match = 1'b1;
        tick();
        clr_match = 1'b0;
    endtask

    task automatic pulse_abort();
        abort = 1'b1;
        tick();
        abort = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        tick(); tick();
        // R11: reset state
        chk("R11 busy", 32'(busy), 0);
        chk("R11 req", 32'(poll_req), 0);
        chk("R11 flag", 32'(match_flag), 0);
        rst_n = 1'b1; enable = 1'b1;
        tick();

        // Table walk: R1 R2 R3 R4 compare rules, R5 stop on hit
        for (int i = 0; i < NV; i++) begin
            pulse_clear();
            start_poll(VECS[i].orm, 1'b1, VECS[i].size, VECS[i].mask, VECS[i].ref_v, 16'd0);
            chk("R12 request after start", 32'(poll_req), 1);
            respond(VECS[i].data);
            chk($sformatf("R1 R2 R3 R4 vector %0d flag", i), 32'(match_flag), 32'(VECS[i].exp_hit));
            chk($sformatf("R5 vector %0d busy", i), 32'(busy), 32'(!VECS[i].exp_hit));
            if (busy) pulse_abort();
        end
        pulse_clear();

        // R10: mode change while busy is ignored
        start_poll(1'b0, 1'b1, 2'd0, 32'h0000_00FF, 32'h0000_000F, 16'd0);
        cfg_or_mode = 1'b1;
        tick();
        respond(32'h0000_000E);
        chk("R10 flag after mid-poll mode change", 32'(match_flag), 0);
        chk("R10 still busy", 32'(busy), 1);
        pulse_abort();
        chk("R9 idle after abort", 32'(busy), 0);

        // R6 R7 continuous polling with interval 3
        start_poll(1'b0, 1'b0, 2'd0, 32'h0000_00FF, 32'h0000_00AA, 16'd3);
        respond(32'h0000_00AA);
        chk("R6 flag on hit", 32'(match_flag), 1);
        chk("R6 busy after hit", 32'(busy), 1);
        begin
            int n = 0;
            while (!poll_req && n < 20) begin n++; tick(); end
            chk("R7 interval low cycles", 32'(n), 3);
        end
        // R8 sticky across a miss
        respond(32'h0000_0055);
        chk("R8 flag sticky", 32'(match_flag), 1);
        chk("R6 busy after miss", 32'(busy), 1);
        pulse_clear();
        chk("R8 flag cleared", 32'(match_flag), 0);
        while (!poll_req) tick();
        // R8 hit beats clear in the same cycle
        clr_match = 1'b1;
        respond(32'h0000_00AA);
        clr_match = 1'b0;
        chk("R8 hit wins over clear", 32'(match_flag), 1);
        // R9 abort during the interval wait
        pulse_abort();
        chk("R9 busy after abort", 32'(busy), 0);
        chk("R9 req after abort", 32'(poll_req), 0);
        pulse_clear();

        // R7 interval zero keeps requesting
        start_poll(1'b0, 1'b0, 2'd0, 32'h0000_00FF, 32'h0000_00AA, 16'd0);
        respond(32'h0000_0011);
        chk("R7 zero interval req", 32'(poll_req), 1);
        // R9 response in the abort cycle is discarded
        abort = 1'b1;
        respond(32'h0000_00AA);
        abort = 1'b0;
        chk("R9 flag after abort with response", 32'(match_flag), 0);
        chk("R9 req dropped", 32'(poll_req), 0);

        // R9 disable drops the engine to idle
        start_poll(1'b0, 1'b0, 2'd0, 32'h0000_00FF, 32'h0000_00AA, 16'd0);
        enable = 1'b0;
        tick();
        chk("R9 busy after disable", 32'(busy), 0);
        // R12 start ignored while disabled
        start = 1'b1;
        tick();
        start = 1'b0;
        tick();
        chk("R12 no start when disabled", 32'(busy), 0);
        enable = 1'b1;
        tick();

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule